// File: doc/BRIEF.md
# Real-Time Clock Register File

This block keeps calendar time in packed BCD and presents it to software as eight byte-wide registers behind a chip-enable, output-enable and write-enable bus. A one-second strobe comes from dividing a 32768 Hz enable pulse. That strobe advances running counters for seconds, minutes, hours, day of week, date, month and year. The registers software sees are a separate copy. They track the counters on every clock unless software freezes them.

Two freeze bits in the control register serve different purposes. The write freeze lets software load a full new time. Clearing it commits that time to the counters and restarts the divider. The read freeze holds the copy steady for a coherent read. The counters keep running underneath, and clearing it commits nothing. The low six bits of control hold a century value, and its update depends on which bit the write sets or clears.

Seconds bit 7 stops the oscillator. Day bit 6 makes bit 0 of seconds, as read on the bus, toggle at 512 Hz. A power-fail input blocks all bus traffic.

Top module: `rtc_regfile`

## Requirements
- R1: After reset, the registers read as follows: control 00h, seconds 00h, minutes 00h, hours 00h, day 01h, date 01h, month 01h, year 00h. The data output enable is low.
- R2: The register addresses are 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month and 7 year. A write happens when ce_n=0 and we_n=0. Read data is driven (dout_en=1) only when ce_n=0, oe_n=0 and we_n=1. Unused bit positions read 0.
- R3: While pwr_fail=1, writes have no effect and dout_en stays 0.
- R4: The seconds counter advances once every TICK_HZ osc_tick pulses. Seconds and minutes wrap after 59, and hours wrap after 23, each carrying into the next field.
- R5: The date wraps to 01 after the last day of the month. April, June, September and November have 30 days. February has 29 days when the binary value of the BCD year is divisible by 4, and 28 otherwise. Month wraps from 12 to 01, carrying into the year. Year wraps from 99 to 00.
- R6: Writing control bit 7 = 1 freezes the user registers so that new values can be loaded. A later control write with bit 7 = 0 copies them into the counters and clears the divider, so the next second takes a full TICK_HZ ticks.
- R7: Control bit 6 = 1 holds the user registers while the counters keep counting. Clearing bit 6 resumes tracking and does not commit any values written meanwhile.
- R8: Control bits 5:0 hold the century. A control write with bit 7 or bit 6 set leaves the century unchanged. So does a write that clears bit 6 while bit 7 was 0. Any other control write loads bits 5:0, including the write that clears bit 7.
- R9: Seconds bit 7 = 1 stops all counting and the test toggle. Writing 0 to that bit restarts counting from where it stopped. The bit reads back as written.
- R10: While day bit 6 = 1 and the oscillator runs, seconds bit 0 on the bus shows a phase that inverts every max(TICK_HZ/1024,1) ticks. Day bit 6 reads back as written.
- R11: Day of week steps at each midnight and wraps from 7 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle enable at the oscillator rate |
| pwr_fail | input | 1 | Power-fail lockout of the bus |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 3 | Register address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when not driven |
| dout_en | output | 1 | Bus drive enable for dout |

## Verification
The bench builds the block with TICK_HZ=8. At that value a second lasts eight osc_tick pulses and the test phase inverts on every tick. Full cascades become short runs: the year wrap, the leap-year February ends and the 30-day month ends. The same setting lets the bench count an exact second after a commit, and it shows the test toggle flip from one tick to the next.

// File: rtl/rtc_regfile.sv
module rtc_regfile #(
  parameter int TICK_HZ = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       pwr_fail,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       we_n,
  input  logic [2:0] addr,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       dout_en
);
  localparam int DIV_W  = $clog2(TICK_HZ);
  localparam int HALF   = (TICK_HZ >= 1024) ? TICK_HZ / 1024 : 1;
  localparam int HALF_W = $clog2(HALF + 1);

  logic [7:0] c_sec, c_min, c_hr, c_date, c_mon, c_yr;
  logic [2:0] c_day;
  logic [7:0] u_sec, u_min, u_hr, u_date, u_mon, u_yr;
  logic [2:0] u_day;
  logic       wfrz, rfrz, osc_stop, ftest, ft_ph;
  logic [5:0] century;
  logic [DIV_W-1:0]  div;
  logic [HALF_W-1:0] ftc;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] m, input logic [7:0] y);
    logic [7:0] yb;
    yb = {4'd0, y[7:4]} * 8'd10 + {4'd0, y[3:0]};
    if (m == 8'h02) return (yb[1:0] == 2'd0) ? 8'h29 : 8'h28;
    if (m == 8'h04 || m == 8'h06 || m == 8'h09 || m == 8'h11) return 8'h30;
    return 8'h31;
  endfunction

  wire acc      = !pwr_fail && !ce_n;
  wire wr       = acc && !we_n;
  wire wr_ctrl  = wr && addr == 3'd0;
  wire run      = !osc_stop;
  wire div_last = div == DIV_W'(TICK_HZ - 1);
  wire sec_stb  = osc_tick && run && div_last;
  wire commit   = wr_ctrl && wfrz && !din[7];
  wire cent_ld  = wr_ctrl && !din[7] && !din[6] && !(rfrz && !wfrz);
  wire follow   = !wfrz && !rfrz;

  assign dout_en = acc && !oe_n && we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div <= '0; ftc <= '0; ft_ph <= 1'b0;
    end else begin
      if (commit) div <= '0;
      else if (osc_tick && run) div <= div_last ? '0 : div + 1'b1;
      if (osc_tick && run) begin
        if (ftc == HALF_W'(HALF - 1)) begin ftc <= '0; ft_ph <= !ft_ph; end
        else ftc <= ftc + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_sec <= 8'h00; c_min <= 8'h00; c_hr <= 8'h00; c_day <= 3'd1;
      c_date <= 8'h01; c_mon <= 8'h01; c_yr <= 8'h00;
    end else if (commit) begin
      c_sec <= u_sec; c_min <= u_min; c_hr <= u_hr; c_day <= u_day;
      c_date <= u_date; c_mon <= u_mon; c_yr <= u_yr;
    end else if (sec_stb) begin
      if (c_sec != 8'h59) c_sec <= bcd_inc(c_sec);
      else begin
        c_sec <= 8'h00;
        if (c_min != 8'h59) c_min <= bcd_inc(c_min);
        else begin
          c_min <= 8'h00;
          if (c_hr != 8'h23) c_hr <= bcd_inc(c_hr);
          else begin
            c_hr  <= 8'h00;
            c_day <= (c_day == 3'd7) ? 3'd1 : c_day + 3'd1;
            if (c_date != last_day(c_mon, c_yr)) c_date <= bcd_inc(c_date);
            else begin
              c_date <= 8'h01;
              if (c_mon != 8'h12) c_mon <= bcd_inc(c_mon);
              else begin
                c_mon <= 8'h01;
                c_yr  <= (c_yr == 8'h99) ? 8'h00 : bcd_inc(c_yr);
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      u_sec <= 8'h00; u_min <= 8'h00; u_hr <= 8'h00; u_day <= 3'd1;
      u_date <= 8'h01; u_mon <= 8'h01; u_yr <= 8'h00;
      osc_stop <= 1'b0; ftest <= 1'b0;
    end else if (wr && addr != 3'd0) begin
      case (addr)
        3'd1: begin u_sec <= {1'b0, din[6:0]}; osc_stop <= din[7]; end
        3'd2: u_min <= {1'b0, din[6:0]};
        3'd3: u_hr <= {2'b0, din[5:0]};
        3'd4: begin u_day <= din[2:0]; ftest <= din[6]; end
        3'd5: u_date <= {2'b0, din[5:0]};
        3'd6: u_mon <= {3'b0, din[4:0]};
        default: u_yr <= din;
      endcase
    end else if (follow) begin
      u_sec <= c_sec; u_min <= c_min; u_hr <= c_hr; u_day <= c_day;
      u_date <= c_date; u_mon <= c_mon; u_yr <= c_yr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wfrz <= 1'b0; rfrz <= 1'b0; century <= 6'd0;
    end else if (wr_ctrl) begin
      wfrz <= din[7];
      rfrz <= din[6];
      if (cent_ld) century <= din[5:0];
    end
  end

  always_comb begin
    dout = 8'h00;
    if (dout_en) begin
      case (addr)
        3'd0: dout = {wfrz, rfrz, century};
        3'd1: dout = {osc_stop, u_sec[6:1], (ftest && run) ? ft_ph : u_sec[0]};
        3'd2: dout = u_min;
        3'd3: dout = u_hr;
        3'd4: dout = {1'b0, ftest, 3'b000, u_day};
        3'd5: dout = u_date;
        3'd6: dout = u_mon;
        default: dout = u_yr;
      endcase
    end
  end

  assert_pf_lockout_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> $stable(century) && $stable(wfrz) && $stable(rfrz));

  assert_commit_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> c_sec == $past(u_sec) && c_min == $past(u_min) && c_yr == $past(u_yr));

  assert_read_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rfrz && !wfrz && !(wr && addr == 3'd1) |=> $stable(u_sec));

  assert_cent_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && (din[7] || din[6]) |=> $stable(century));

  assert_osc_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop && !commit |=> $stable(c_sec) && $stable(c_min));
endmodule

// File: tb/rtc_regfile_test.sv
module rtc_regfile_test;
  localparam int HZ = 8;
  logic clk = 0, rst_n = 0, osc_tick = 0, pwr_fail = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1;
  logic [2:0] addr = 0;
  logic [7:0] din = 0;
  logic [7:0] dout;
  logic dout_en;
  int checks = 0, fails = 0;

  rtc_regfile #(.TICK_HZ(HZ)) uut (.clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .pwr_fail(pwr_fail), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .din(din), .dout(dout), .dout_en(dout_en));

  always #5 clk = !clk;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 0; we_n = 0; addr = a; din = d;
    @(negedge clk); ce_n = 1; we_n = 1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v, output logic en);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = a;
    #1; v = dout; en = dout_en;
    @(negedge clk); ce_n = 1; oe_n = 1;
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [7:0] e);
    logic [7:0] v; logic en;
    rd(a, v, en);
    chk(req, {7'd0, en}, 8'd1);
    chk(req, v, e);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_tick = 1;
      @(negedge clk); osc_tick = 0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, dw, dt, mo, y, input logic [5:0] cen);
    wr(0, 8'h80);
    wr(1, s); wr(2, mi); wr(3, h); wr(4, dw); wr(5, dt); wr(6, mo); wr(7, y);
    wr(0, {2'b00, cen});
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    expect_reg("R1", 0, 8'h00); expect_reg("R1", 1, 8'h00);
    expect_reg("R1", 2, 8'h00); expect_reg("R1", 3, 8'h00);
    expect_reg("R1", 4, 8'h01); expect_reg("R1", 5, 8'h01);
    expect_reg("R1", 6, 8'h01); expect_reg("R1", 7, 8'h00);
  endtask

  task automatic t_bus;
    @(negedge clk); #1; chk("R1 idle", {7'd0, dout_en}, 8'd0);
    ce_n = 0; oe_n = 1; we_n = 1; addr = 4; #1;
    chk("R2 oe high", {7'd0, dout_en}, 8'd0);
    ce_n = 1; oe_n = 0; #1;
    chk("R2 ce high", {7'd0, dout_en}, 8'd0);
    ce_n = 0; oe_n = 0; we_n = 0; addr = 2; din = 8'h00; #1;
    chk("R2 write cycle", {7'd0, dout_en}, 8'd0);
    @(negedge clk); ce_n = 1; oe_n = 1; we_n = 1;
  endtask

  task automatic t_pwr;
    logic [7:0] v; logic en;
    pwr_fail = 1;
    wr(0, 8'h3F);
    wr(1, 8'h80);
    rd(0, v, en);
    chk("R3 read blocked", {7'd0, en}, 8'd0);
    pwr_fail = 0;
    expect_reg("R3 ctrl kept", 0, 8'h00);
    ticks(HZ);
    expect_reg("R3 osc not stopped", 1, 8'h01);
  endtask

  task automatic t_set_and_roll;
    set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 6'h20);
    expect_reg("R8 century on W clear", 0, 8'h20);
    expect_reg("R6 loaded", 1, 8'h58);
    ticks(HZ - 1);
    expect_reg("R6 full second", 1, 8'h58);
    ticks(1);
    expect_reg("R4 second step", 1, 8'h59);
    ticks(HZ);
    expect_reg("R4 sec wrap", 1, 8'h00); expect_reg("R4 min wrap", 2, 8'h00);
    expect_reg("R4 hr wrap", 3, 8'h00); expect_reg("R11 dow wrap", 4, 8'h01);
    expect_reg("R5 date wrap", 5, 8'h01); expect_reg("R5 month wrap", 6, 8'h01);
    expect_reg("R5 year wrap", 7, 8'h00);
  endtask

  task automatic t_months;
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24, 6'h20);
    ticks(HZ);
    expect_reg("R5 leap feb28", 5, 8'h29); expect_reg("R5 leap feb28 mon", 6, 8'h02);
    expect_reg("R11 dow step", 4, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 8'h24, 6'h20);
    ticks(HZ);
    expect_reg("R5 leap feb29", 5, 8'h01); expect_reg("R5 leap feb29 mon", 6, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 6'h20);
    ticks(HZ);
    expect_reg("R5 common feb", 5, 8'h01); expect_reg("R5 common feb mon", 6, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h09, 8'h23, 6'h20);
    ticks(HZ);
    expect_reg("R5 sep30", 5, 8'h01); expect_reg("R5 sep->oct", 6, 8'h10);
  endtask

  task automatic t_read_freeze;
    set_time(8'h10, 8'h00, 8'h12, 8'h03, 8'h15, 8'h06, 8'h30, 6'h20);
    wr(0, 8'h45);
    expect_reg("R8 set R keeps century", 0, 8'h60);
    expect_reg("R7 frozen", 1, 8'h10);
    ticks(HZ);
    expect_reg("R7 still frozen", 1, 8'h10);
    wr(1, 8'h33);
    wr(0, 8'h05);
    repeat (2) @(negedge clk);
    expect_reg("R8 clear R keeps century", 0, 8'h20);
    expect_reg("R7 no commit", 1, 8'h11);
    wr(0, 8'h8A);
    expect_reg("R8 set W keeps century", 0, 8'hA0);
    wr(0, 8'h20);
    repeat (2) @(negedge clk);
    expect_reg("R6 commit snapshot", 1, 8'h11);
  endtask

  task automatic t_osc;
    wr(1, 8'h80);
    repeat (2) @(negedge clk);
    expect_reg("R9 stop bit", 1, 8'h91);
    ticks(2 * HZ);
    expect_reg("R9 halted", 1, 8'h91);
    wr(1, 8'h00);
    ticks(HZ);
    expect_reg("R9 restarted", 1, 8'h12);
  endtask

  task automatic t_ftest;
    logic [7:0] a, b; logic en;
    wr(4, 8'h43);
    repeat (2) @(negedge clk);
    expect_reg("R10 bit readback", 4, 8'h43);
    rd(1, a, en);
    ticks(1);
    rd(1, b, en);
    chk("R10 toggle", {7'd0, b[0]}, {7'd0, !a[0]});
    ticks(1);
    rd(1, b, en);
    chk("R10 toggle back", {7'd0, b[0]}, {7'd0, a[0]});
    wr(4, 8'h03);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_bus();
    t_pwr();
    t_set_and_roll();
    t_months();
    t_read_freeze();
    t_osc();
    t_ftest();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule